// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a single-clock synchronous static memory in which every control input passes through an input register and every read result leaves through an output register. A write is issued as a command (address plus per-lane write selects) on one rising edge. Its data is presented on the following rising edge. The data then sits in a holding register for one more cycle before it reaches the array. A read that arrives while its address still has a pending write in that holding register gets the pending bytes merged over the array bytes, lane by lane.

The word is split into 9-bit lanes: four lanes give a 36-bit word and two lanes give an 18-bit word. A parameter picks between them. A sleep input freezes the command path while memory contents are kept. After sleep is released, commands are turned into deselects for a parameterised number of clock cycles. The output holds its last read value whenever no read completes.

Top module: `latewr_sram`

## Requirements
- R1: `addr`, `ce_n`, `we_n` and `bsel_n` are captured on the rising clock edge. A write updates only lane i (data bits [9i+8:9i]) where `bsel_n[i]` was 0 on the command edge. Other lanes keep their contents.
- R2: The data for a write is taken from `wdata` on the rising edge one cycle after the write command's edge.
- R3: The word at a read address appears on `rdata` after the second rising edge following the edge that captured the read command.
- R4: `bsel_n` has no effect on a read command (`we_n` = 1): no lane is written.
- R5: An edge that samples `ce_n` = 1 performs no access, even with `we_n` = 0.
- R6: A read whose address matches a write whose data has been taken but not yet stored returns the new data on the selected lanes and the old data on the others.
- R7: `rdata` keeps its value across every cycle in which no read result completes (writes, deselects, sleep).
- R8: An edge that samples `sleep` = 1 ignores the command inputs, and memory contents are preserved.
- R9: After `sleep` drops, the first REC_CYC edges that sample `sleep` = 0 treat every command as a deselect. The edge after them accepts commands again.
- R10: While `rst_n` is low, `rdata` is cleared to zero and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address of the command |
| ce_n | input | 1 | Chip enable, active low; high means deselect |
| we_n | input | 1 | Write enable, active low; high means read |
| bsel_n | input | LANES | Per-lane write selects, active low |
| wdata | input | 9*LANES | Write data, sampled one edge after its command |
| sleep | input | 1 | Low-activity request; commands ignored while high |
| rdata | output | 9*LANES | Registered read data |

## Verification
The functions that coincide are the store of held write data into the array and a read of that same address, both on one edge. The bench provokes this by issuing a write command and, on the very next edge, a read of the same address. It does this once with all lanes selected and once with a partial lane mask over a word that already holds a known pattern. The scoreboard expects the merged word (new lanes from the write, old lanes from the earlier contents) exactly two edges after the read. Any missing or wrong forwarding shows up as stale bytes.

// File: rtl/latewr_sram_pkg.sv
// Package: shared types for the late-write SRAM.
// Assumes: a command decodes to one of three operations after the input stage.
package latewr_sram_pkg;

    // Lane width in bits: one byte plus one extra bit.
    localparam int LANE_W = 9;

    // Operation captured by the input stage on a rising edge.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/latewr_cmd_stage.sv
// Input register stage. Samples address, enables and lane selects on the
// rising edge and decodes them into an operation. It also holds the sleep
// and recovery gating: while sleep is sampled high, and for REC_CYC edges
// after it drops, every command becomes idle.
// Assumes: sleep is synchronous to clk.
module latewr_cmd_stage
    import latewr_sram_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int ADDR_W  = 6,
    parameter int REC_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  bsel_n,
    input  logic              sleep,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  mask_q
);

    localparam int CNT_W = $clog2(REC_CYC + 2);

    logic [CNT_W-1:0] rec_cnt;
    logic             blocked;
    logic             take;

    // A command is blocked while sleeping or while recovery runs.
    assign blocked = sleep || (rec_cnt != '0);
    assign take    = !ce_n && !blocked;

    // Recovery counter: reloaded during sleep, counts down afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_cnt <= '0;
        end else if (sleep) begin
            rec_cnt <= CNT_W'(REC_CYC);
        end else if (rec_cnt != '0) begin
            rec_cnt <= rec_cnt - 1'b1;
        end
    end

    // Operation register: decodes an accepted command, else idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_IDLE;
        end else if (!take) begin
            op_q <= OP_IDLE;
        end else if (we_n) begin
            op_q <= OP_READ;
        end else begin
            op_q <= OP_WRITE;
        end
    end

    // Address and active-high lane mask registers for an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '0;
        end else if (take) begin
            addr_q <= addr;
            mask_q <= we_n ? '0 : ~bsel_n;
        end
    end

endmodule

// File: rtl/latewr_wr_hold.sv
// Late-write holding register. One edge after a write command it captures
// the write data together with the command's address and lane mask. The
// content is presented to the array for storage on the following edge.
// Assumes: a write command lasts a single cycle in op_q.
module latewr_wr_hold
    import latewr_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 6,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [LANES-1:0]  mask_q,
    input  logic [DW-1:0]     wdata,
    output logic              hold_vld,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [LANES-1:0]  hold_mask,
    output logic [DW-1:0]     hold_data
);

    logic is_wr;

    assign is_wr = (op_q == OP_WRITE);

    // Valid flag: set for exactly one cycle per write command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld <= 1'b0;
        end else begin
            hold_vld <= is_wr;
        end
    end

    // Payload: address, mask and late data of the current write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_mask <= '0;
            hold_data <= '0;
        end else if (is_wr) begin
            hold_addr <= addr_q;
            hold_mask <= mask_q;
            hold_data <= wdata;
        end
    end

endmodule

// File: rtl/latewr_array.sv
// Memory array built from one storage column per lane. A write stores only
// the lanes set in wr_mask. A read is synchronous and returns the content
// from before any write on the same edge.
// Assumes: the array itself is not reset.
module latewr_array
    import latewr_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 6,
    localparam int DW    = LANES * LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_word
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] col [DEPTH];

        // Lane store: written only when its mask bit is set.
        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) begin
                col[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        // Lane fetch: registered read of the old content.
        always_ff @(posedge clk) begin
            if (rd_en) begin
                rd_word[g*LANE_W +: LANE_W] <= col[rd_addr];
            end
        end
    end

endmodule

// File: rtl/latewr_read_path.sv
// Read pipeline. On the array-access edge it records whether the holding
// register carries newer data for the read address. It then merges those
// lanes over the array word, and the output register captures the result
// on the next edge. rdata changes only when a read completes.
// Assumes: the array read and the hold store happen on the same edge.
module latewr_read_path
    import latewr_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 6,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              hold_vld,
    input  logic [ADDR_W-1:0] hold_addr,
    input  logic [LANES-1:0]  hold_mask,
    input  logic [DW-1:0]     hold_data,
    input  logic [DW-1:0]     arr_word,
    output logic              rd_stage_vld,
    output logic [DW-1:0]     rdata
);

    logic             is_rd;
    logic             fwd_hit;
    logic [LANES-1:0] fwd_mask;
    logic [DW-1:0]    fwd_data;
    logic [DW-1:0]    merged;

    assign is_rd = (op_q == OP_READ);

    // Read-stage valid: marks the cycle in which the array word is ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_stage_vld <= 1'b0;
        end else begin
            rd_stage_vld <= is_rd;
        end
    end

    // Forwarding snapshot: pending write data that matches the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_hit  <= 1'b0;
            fwd_mask <= '0;
            fwd_data <= '0;
        end else if (is_rd) begin
            fwd_hit  <= hold_vld && (hold_addr == addr_q);
            fwd_mask <= hold_mask;
            fwd_data <= hold_data;
        end
    end

    // Lane merge: pending lanes win over the array word.
    for (genvar g = 0; g < LANES; g++) begin : g_merge
        always_comb begin
            if (fwd_hit && fwd_mask[g]) begin
                merged[g*LANE_W +: LANE_W] = fwd_data[g*LANE_W +: LANE_W];
            end else begin
                merged[g*LANE_W +: LANE_W] = arr_word[g*LANE_W +: LANE_W];
            end
        end
    end

    // Output register: loads only when a read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_stage_vld) begin
            rdata <= merged;
        end
    end

endmodule

// File: rtl/latewr_sram.sv
// Top of the pipelined late-write SRAM. It chains the input stage, the
// late-write holding register, the lane-wise array and the forwarding read
// path. Read latency is two edges; write data follows its command by one
// edge.
// Assumes: LANES is 2 or 4; REC_CYC counts clock cycles.
module latewr_sram
    import latewr_sram_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int ADDR_W  = 6,
    parameter int REC_CYC = 3,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  bsel_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sleep,
    output logic [DATA_W-1:0] rdata
);

    // Only the two word organisations are supported.
    initial begin
        if (LANES != 2 && LANES != 4) begin
            $error("latewr_sram: LANES must be 2 or 4");
        end
    end

    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LANES-1:0]  cmd_mask;
    logic              cmd_rd;
    logic              cmd_wr;
    logic              hold_vld;
    logic [ADDR_W-1:0] hold_addr;
    logic [LANES-1:0]  hold_mask;
    logic [DATA_W-1:0] hold_data;
    logic [DATA_W-1:0] arr_word;
    logic              rd_stage_vld;

    assign cmd_rd = (cmd_op == OP_READ);
    assign cmd_wr = (cmd_op == OP_WRITE);

    latewr_cmd_stage #(
        .LANES   (LANES),
        .ADDR_W  (ADDR_W),
        .REC_CYC (REC_CYC)
    ) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .bsel_n (bsel_n),
        .sleep  (sleep),
        .op_q   (cmd_op),
        .addr_q (cmd_addr),
        .mask_q (cmd_mask)
    );

    latewr_wr_hold #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_q      (cmd_op),
        .addr_q    (cmd_addr),
        .mask_q    (cmd_mask),
        .wdata     (wdata),
        .hold_vld  (hold_vld),
        .hold_addr (hold_addr),
        .hold_mask (hold_mask),
        .hold_data (hold_data)
    );

    latewr_array #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (hold_vld),
        .wr_addr (hold_addr),
        .wr_mask (hold_mask),
        .wr_data (hold_data),
        .rd_en   (cmd_rd),
        .rd_addr (cmd_addr),
        .rd_word (arr_word)
    );

    latewr_read_path #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_q         (cmd_op),
        .addr_q       (cmd_addr),
        .hold_vld     (hold_vld),
        .hold_addr    (hold_addr),
        .hold_mask    (hold_mask),
        .hold_data    (hold_data),
        .arr_word     (arr_word),
        .rd_stage_vld (rd_stage_vld),
        .rdata        (rdata)
    );

endmodule

// File: rtl/latewr_sram_chk.sv
// Checker for the late-write SRAM, bound into the top module. It relates
// the ports to the stage flags driven by the separate pipeline modules.
module latewr_sram_chk #(
    parameter int DW      = 36,
    parameter int REC_CYC = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          sleep,
    input logic [DW-1:0] rdata,
    input logic          cmd_rd,
    input logic          cmd_wr,
    input logic          hold_vld,
    input logic          rd_stage_vld
);

    // R2: a write command is followed by held data on the next edge.
    a_r2_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> hold_vld);

    // R3: a read command reaches the array-word stage on the next edge.
    a_r3_read_stage: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |=> rd_stage_vld);

    // R5: a deselect edge produces no operation.
    a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!cmd_rd && !cmd_wr));

    // R7: without a completing read the output holds.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stage_vld |=> $stable(rdata));

    // R8: a sleeping edge produces no operation.
    a_r8_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (!cmd_rd && !cmd_wr));

    // R9: the first edge after sleep drops is still a deselect.
    if (REC_CYC >= 1) begin : g_rec
        a_r9_recovery: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sleep) |=> (!cmd_rd && !cmd_wr));
    end

endmodule

bind latewr_sram latewr_sram_chk #(
    .DW      (DATA_W),
    .REC_CYC (REC_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_n         (ce_n),
    .sleep        (sleep),
    .rdata        (rdata),
    .cmd_rd       (cmd_rd),
    .cmd_wr       (cmd_wr),
    .hold_vld     (hold_vld),
    .rd_stage_vld (rd_stage_vld)
);

// File: tb/latewr_sram_bench.sv
// Scoreboard bench: the driver task keeps a reference memory and queues the
// expected read results; the monitor compares them on their due cycle.
module latewr_sram_bench;

    localparam int L   = 4;
    localparam int AW  = 6;
    localparam int REC = 3;
    localparam int DW  = L * 9;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_n;
    logic          we_n;
    logic [L-1:0]  bsel_n;
    logic [DW-1:0] wdata;
    logic          sleep;
    logic [DW-1:0] rdata;

    latewr_sram #(.LANES(L), .ADDR_W(AW), .REC_CYC(REC)) u_latewr_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .bsel_n(bsel_n), .wdata(wdata), .sleep(sleep), .rdata(rdata)
    );

    always #5 clk = ~clk;

    typedef struct {
        int            due;
        logic [DW-1:0] val;
        string         req;
    } exp_t;

    exp_t          q[$];
    int            cyc = 0;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;
    logic [DW-1:0] mdl [1 << AW];
    logic [DW-1:0] pend;
    bit            pend_v = 1'b0;
    int            rec = 0;
    bit            slp = 1'b0;
    logic [DW-1:0] last_exp = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item that falls due in this cycle.
    always @(negedge clk) begin
        while (q.size() != 0 && q[0].due == cyc) begin
            n_chk++;
            if (rdata !== q[0].val) begin
                n_bad++;
                $display("FAIL %s: rdata=%h expected=%h", q[0].req, rdata, q[0].val);
            end
            void'(q.pop_front());
        end
    end

    // Driver: one command per cycle, late data for the previous write.
    task automatic step(input logic c, input logic w, input logic [AW-1:0] a,
                        input logic [L-1:0] b, input logic [DW-1:0] d, input string req);
        bit blk;
        exp_t e;
        @(negedge clk);
        ce_n = c; we_n = w; addr = a; bsel_n = b; sleep = slp;
        wdata = pend_v ? pend : {L{9'h1A5}};
        blk = slp || (rec > 0);
        if (slp) rec = REC;
        else if (rec > 0) rec--;
        pend_v = 1'b0;
        if (!c && !blk) begin
            if (!w) begin
                for (int i = 0; i < L; i++)
                    if (!b[i]) mdl[a][i*9 +: 9] = d[i*9 +: 9];
                pend = d; pend_v = 1'b1;
            end else begin
                e.due = cyc + 3; e.val = mdl[a]; e.req = req;
                q.push_back(e);
                last_exp = mdl[a];
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, '0, '1, '0, "");
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [L-1:0] b, input logic [DW-1:0] d);
        step(1'b0, 1'b0, a, b, d, "");
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req);
        step(1'b0, 1'b1, a, '1, '0, req);
    endtask

    // Queue a hold check: rdata must still show the last read result.
    task automatic expect_hold(input string req);
        exp_t e;
        e.due = cyc + 3; e.val = last_exp; e.req = req;
        q.push_back(e);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: cycles=%0d expected=finish", cyc);
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; addr = '0; bsel_n = '1;
        wdata = '0; sleep = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: output cleared by reset
        n_chk++;
        if (rdata !== '0) begin
            n_bad++;
            $display("FAIL R10: rdata=%h expected=%h", rdata, {DW{1'b0}});
        end

        // R1, R2, R3: full writes then reads after the pipeline drains
        wr(6'd0, 4'b0000, 36'h1_2345_6789);
        wr(6'd1, 4'b0000, 36'hF_EDCB_A987);
        wr(6'd3, 4'b0000, 36'hA_AAAA_AAAA);
        idle(2);
        rd(6'd0, "R3");
        rd(6'd1, "R2");
        // R1: partial write of lanes 0 and 2
        wr(6'd0, 4'b1010, 36'h5_5555_5555);
        idle(2);
        rd(6'd0, "R1");
        // R6: read right after a full write to the same address
        wr(6'd2, 4'b0000, 36'h3_C3C3_C3C3);
        rd(6'd2, "R6");
        // R6: partial write over a known word, read on the next edge
        wr(6'd3, 4'b0110, 36'h0_1234_5678);
        rd(6'd3, "R6");
        // R2: read two edges after a write, from the array
        wr(6'd4, 4'b0000, 36'h9_8765_4321);
        idle(1);
        rd(6'd4, "R2");
        // R4: read with all selects low writes nothing
        step(1'b0, 1'b1, 6'd1, 4'b0000, 36'h0_0000_0000, "R4");
        idle(2);
        rd(6'd1, "R4");
        // R5: deselect with write enable low performs no write
        step(1'b1, 1'b0, 6'd1, 4'b0000, 36'h0_0000_0000, "");
        idle(3);
        expect_hold("R7");
        rd(6'd1, "R5");
        idle(4);
        // R8: sleep ignores writes and reads, R7 hold during sleep
        slp = 1'b1;
        wr(6'd1, 4'b0000, 36'h7_7777_7777);
        rd(6'd0, "");
        idle(2);
        expect_hold("R7");
        idle(2);
        slp = 1'b0;
        // R9: REC edges of recovery, then commands accepted again
        for (int i = 0; i < REC; i++) wr(6'd1, 4'b0000, 36'h6_6666_6666);
        wr(6'd5, 4'b0000, 36'h2_4681_3579);
        idle(2);
        rd(6'd1, "R8");
        rd(6'd5, "R9");
        rd(6'd0, "R8");
        idle(6);
        if (q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R3: pending=%0d expected=0", q.size());
        end
        done = 1'b1;
        summary();
    end

endmodule